// File: doc/BRIEF.md
# Byte-Oriented Two-Wire Bus Master Sequencer

This block is a two-wire serial bus master that software steers through three small registers: a control register, a status register and a data register. Software asks for a START, a STOP or a byte transfer by setting bits in the control register. It then writes one to the completion flag, which clears it and launches the operation. The engine carries out the bus action on open-drain clock and data lines. When the action finishes, it raises the completion flag again and posts a status code that tells software what happened.

While the completion flag is high, the engine takes no further step. It keeps holding the clock line where the last action left it, so software sets the pace of the whole transfer. The block watches the bus for START and STOP conditions from other masters. A START request that arrives while another master owns the bus is held back until that master releases the bus with a STOP. The bit period is a base divider times a prescaler of 1, 4, 16 or 64, selected by two status-register bits.

Top module: `i2c_seq_master`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the status register (address 1) reads 0xF8, the data register (address 2) reads 0xFF, irq is low and both line drivers are off.
- R2: The completion flag is control bit 7. Writing 1 to it clears it and writing 0 leaves it alone. While it is set, the engine drives no new bus activity and the line drivers keep their levels. An operation starts only after the flag is cleared.
- R3: With the enable bit (control bit 2) set and the START bit (control bit 5) set, clearing the completion flag on a free bus produces a START: SDA falls while SCL is high. The engine then sets the flag and reports status 0x08. The START bit still reads 1 afterwards.
- R4: If another master has made the bus busy with a START, a START request waits with both drivers off and the flag clear. It is issued only after that master's STOP has been seen, and it then reports 0x08.
- R5: A byte launched while the engine is bus master is sent MSB first, with a ninth clock for acknowledge; SDA low on that clock means ACK. The first byte after a START reports 0x18 (ACK) or 0x20 (NACK). Later bytes report 0x28 (ACK) or 0x30 (NACK).
- R6: As bus master, the STOP bit (control bit 4) makes the engine produce a STOP: SDA rises while SCL is high. The STOP bit then reads 0, the completion flag stays clear and the status reads 0xF8.
- R7: When the engine is not bus master, the STOP bit causes no bus condition. Both drivers stay released, the STOP bit clears itself and the status reads 0xF8.
- R8: Writing the data register while the completion flag is clear sets the collision flag (control bit 3, read-only) and leaves the data register unchanged. A data write while the flag is set stores the byte and clears the collision flag.
- R9: Clearing the enable bit aborts any operation in progress at once and turns both line drivers off.
- R10: irq is high exactly while both the completion flag and the interrupt-enable bit (control bit 0) are set.
- R11: Status bits 1..0 are the writable prescaler select, bit 2 always reads 0, and bits 7..3 hold the status code. Each SCL period of a byte lasts 4*BASE_DIV*D clocks, where D is 1, 4, 16 or 64 for select values 0 to 3.
- R12: After a byte transfer, the data register holds the byte seen on the bus.
- R13: A START requested while the engine already owns the bus is issued as a repeated START and reports status 0x10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| scl_i | input | 1 | Sensed level of the clock line |
| sda_i | input | 1 | Sensed level of the data line |
| scl_oe | output | 1 | Pull the clock line low when high |
| sda_oe | output | 1 | Pull the data line low when high |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can meet in the same cycle: a data-register write from software and a byte transfer that is still shifting and about to post its completion. The bench provokes this by writing a different byte to the data register right after launching each transfer. It then judges the collision flag while the transfer is in flight, and the data register once the completion flag rises; the register must hold the byte seen on the bus, not the late write. This is swept over every prescaler select, with the ACK and NACK answers from the bench's slave model alternating, and the expected bit periods and status codes are computed in the bench.

// File: rtl/i2c_seq_pkg.sv
// Package: shared constants and types of the two-wire master sequencer.
// Assumes: status codes are kept as the 5-bit field that sits in bits 7..3.
package i2c_seq_pkg;

    // Register addresses on the software port
    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;

    // Control register bit positions
    localparam int CB_DONE = 7;
    localparam int CB_STA  = 5;
    localparam int CB_STO  = 4;
    localparam int CB_EN   = 2;
    localparam int CB_IE   = 0;

    // 5-bit status codes (value shown in the status register is code << 3)
    localparam logic [4:0] CODE_START     = 5'h01;
    localparam logic [4:0] CODE_RSTART    = 5'h02;
    localparam logic [4:0] CODE_ADDR_ACK  = 5'h03;
    localparam logic [4:0] CODE_ADDR_NACK = 5'h04;
    localparam logic [4:0] CODE_DATA_ACK  = 5'h05;
    localparam logic [4:0] CODE_DATA_NACK = 5'h06;
    localparam logic [4:0] CODE_IDLE      = 5'h1F;

    // Engine sequencing states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_START,
        ST_BYTE,
        ST_STOP
    } eng_state_t;

endpackage

// File: rtl/i2c_seq_tick.sv
// Module: quarter-bit tick generator.
// Emits a one-cycle tick every BASE_DIV * 4^sel clocks. Four ticks make one
// SCL period. Assumes BASE_DIV >= 2 so bus edges settle between ticks.
module i2c_seq_tick #(
    parameter int BASE_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int NSEL  = 4;
    localparam int CNT_W = $clog2(BASE_DIV * 64 + 1);

    logic [CNT_W-1:0] lim_tab [NSEL];
    logic [CNT_W-1:0] cnt;

    // One terminal count per prescaler select
    for (genvar g = 0; g < NSEL; g++) begin : g_lim
        assign lim_tab[g] = CNT_W'(BASE_DIV * (1 << (2 * g)) - 1);
    end

    // Free-running divider; restarts on reaching the selected limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= lim_tab[sel]) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_seq_busmon.sv
// Module: bus-busy tracker.
// Sets busy on a START (SDA falling with SCL high) and clears it on a STOP
// (SDA rising with SCL high), including conditions the engine makes itself.
// Assumes the line inputs are already synchronous to clk.
module i2c_seq_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic scl_i,
    input  logic sda_i,
    output logic busy
);
    logic scl_d;
    logic sda_d;
    logic start_seen;
    logic stop_seen;

    // Condition decode from the previous and present line levels
    always_comb begin
        start_seen = scl_d && scl_i && sda_d && !sda_i;
        stop_seen  = scl_d && scl_i && !sda_d && sda_i;
    end

    // Line history and busy state; idle while the block is disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
            busy  <= 1'b0;
        end else begin
            scl_d <= scl_i;
            sda_d <= sda_i;
            if (start_seen)
                busy <= 1'b1;
            else if (stop_seen)
                busy <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_seq_engine.sv
// Module: bus sequencing engine.
// Runs one START, repeated START, byte or STOP per launch, stepping on
// quarter-bit ticks, then pulses evt with a status code (or sto_clr after
// a STOP). Assumes go stays low from the evt pulse until software re-arms.
module i2c_seq_engine
    import i2c_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       go,
    input  logic       sta,
    input  logic       sto,
    input  logic       busy,
    input  logic       tick,
    input  logic       sda_i,
    input  logic [7:0] tx_byte,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       master,
    output logic       evt,
    output logic       sto_clr,
    output logic [4:0] evt_code,
    output logic [7:0] evt_byte
);
    localparam int BITS_PER_XFER = 9;
    localparam int BIT_W = $clog2(BITS_PER_XFER + 1);
    localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(BITS_PER_XFER - 1);

    eng_state_t       st;
    logic [1:0]       q;
    logic [BIT_W-1:0] bitn;
    logic [7:0]       shreg;
    logic             ack_n;
    logic             first;
    logic [4:0]       byte_code;

    // Status code for a finished byte: address phase or data phase
    always_comb begin
        if (first)
            byte_code = ack_n ? CODE_ADDR_NACK : CODE_ADDR_ACK;
        else
            byte_code = ack_n ? CODE_DATA_NACK : CODE_DATA_ACK;
    end

    // Sequencer: decide the operation, then step it quarter by quarter
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st       <= ST_IDLE;
            q        <= 2'd0;
            bitn     <= '0;
            shreg    <= 8'h00;
            ack_n    <= 1'b1;
            first    <= 1'b0;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
            master   <= 1'b0;
            evt      <= 1'b0;
            sto_clr  <= 1'b0;
            evt_code <= CODE_IDLE;
            evt_byte <= 8'hFF;
        end else begin
            evt     <= 1'b0;
            sto_clr <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (go) begin
                        if (sto) begin
                            if (master) begin
                                st <= ST_STOP;
                                q  <= 2'd0;
                            end else begin
                                sto_clr <= 1'b1;
                                scl_oe  <= 1'b0;
                                sda_oe  <= 1'b0;
                            end
                        end else if (sta) begin
                            q  <= 2'd0;
                            st <= (busy && !master) ? ST_WAIT : ST_START;
                        end else if (master) begin
                            st    <= ST_BYTE;
                            q     <= 2'd0;
                            bitn  <= '0;
                            shreg <= tx_byte;
                        end
                    end
                end
                ST_WAIT: begin
                    if (!sta)
                        st <= ST_IDLE;
                    else if (!busy) begin
                        st <= ST_START;
                        q  <= 2'd0;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        q <= q + 2'd1;
                        case (q)
                            2'd0: sda_oe <= 1'b0;
                            2'd1: scl_oe <= 1'b0;
                            2'd2: sda_oe <= 1'b1;
                            default: begin
                                scl_oe   <= 1'b1;
                                evt      <= 1'b1;
                                evt_code <= master ? CODE_RSTART : CODE_START;
                                evt_byte <= tx_byte;
                                master   <= 1'b1;
                                first    <= 1'b1;
                                st       <= ST_IDLE;
                            end
                        endcase
                    end
                end
                ST_BYTE: begin
                    if (tick) begin
                        q <= q + 2'd1;
                        case (q)
                            2'd0: sda_oe <= (bitn == ACK_SLOT) ? 1'b0 : !shreg[7];
                            2'd1: scl_oe <= 1'b0;
                            2'd2: begin
                                if (bitn == ACK_SLOT)
                                    ack_n <= sda_i;
                                else
                                    shreg <= {shreg[6:0], sda_i};
                            end
                            default: begin
                                scl_oe <= 1'b1;
                                if (bitn == ACK_SLOT) begin
                                    evt      <= 1'b1;
                                    evt_code <= byte_code;
                                    evt_byte <= shreg;
                                    first    <= 1'b0;
                                    st       <= ST_IDLE;
                                end else begin
                                    bitn <= bitn + 1'b1;
                                end
                            end
                        endcase
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        q <= q + 2'd1;
                        case (q)
                            2'd0: sda_oe <= 1'b1;
                            2'd1: scl_oe <= 1'b0;
                            2'd2: sda_oe <= 1'b0;
                            default: begin
                                master  <= 1'b0;
                                sto_clr <= 1'b1;
                                st      <= ST_IDLE;
                            end
                        endcase
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_seq_master.sv
// Module: register-driven two-wire bus master (top).
// Holds the control, status and data registers, gates the engine with the
// completion flag and raises irq. Assumes scl_i/sda_i are synchronous and
// that the pads pull a line low while its _oe output is high.
module i2c_seq_master
    import i2c_seq_pkg::*;
#(
    parameter int BASE_DIV = 4,
    parameter int ADDR_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              irq
);
    logic       done_q, sta_q, sto_q, en_q, ie_q, wcol_q;
    logic [4:0] code_q;
    logic [1:0] presc_q;
    logic [7:0] data_q;

    logic       ctrl_wr, stat_wr, data_wr;
    logic       go, tick, busy;
    logic       evt, sto_clr, eng_master;
    logic [4:0] evt_code;
    logic [7:0] evt_byte;

    // Register-port write decode
    always_comb begin
        ctrl_wr = reg_wr && (reg_addr == ADDR_W'(REG_CTRL));
        stat_wr = reg_wr && (reg_addr == ADDR_W'(REG_STAT));
        data_wr = reg_wr && (reg_addr == ADDR_W'(REG_DATA));
    end

    // Launch permission: flag clear and no completion in flight
    assign go  = !done_q && !evt;
    assign irq = done_q && ie_q;

    // Control register: completion flag, requests, enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            sta_q  <= 1'b0;
            sto_q  <= 1'b0;
            en_q   <= 1'b0;
            ie_q   <= 1'b0;
        end else begin
            if (evt)
                done_q <= 1'b1;
            else if (ctrl_wr && reg_wdata[CB_DONE])
                done_q <= 1'b0;
            if (ctrl_wr) begin
                sta_q <= reg_wdata[CB_STA];
                sto_q <= reg_wdata[CB_STO];
                en_q  <= reg_wdata[CB_EN];
                ie_q  <= reg_wdata[CB_IE];
            end else if (sto_clr) begin
                sto_q <= 1'b0;
            end
        end
    end

    // Status register: code from the engine, prescaler from software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= CODE_IDLE;
            presc_q <= 2'b00;
        end else begin
            if (evt)
                code_q <= evt_code;
            else if (sto_clr)
                code_q <= CODE_IDLE;
            if (stat_wr)
                presc_q <= reg_wdata[1:0];
        end
    end

    // Data register and write-collision flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= 8'hFF;
            wcol_q <= 1'b0;
        end else begin
            if (evt)
                data_q <= evt_byte;
            else if (data_wr && done_q)
                data_q <= reg_wdata;
            if (data_wr)
                wcol_q <= !done_q;
        end
    end

    // Register read mux
    always_comb begin
        case (reg_addr)
            ADDR_W'(REG_CTRL): reg_rdata = {done_q, 1'b0, sta_q, sto_q, wcol_q, en_q, 1'b0, ie_q};
            ADDR_W'(REG_STAT): reg_rdata = {code_q, 1'b0, presc_q};
            ADDR_W'(REG_DATA): reg_rdata = data_q;
            default:           reg_rdata = 8'h00;
        endcase
    end

    i2c_seq_tick #(.BASE_DIV(BASE_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (presc_q),
        .tick  (tick)
    );

    i2c_seq_busmon u_busmon (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_q),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .busy  (busy)
    );

    i2c_seq_engine u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_q),
        .go       (go),
        .sta      (sta_q),
        .sto      (sto_q),
        .busy     (busy),
        .tick     (tick),
        .sda_i    (sda_i),
        .tx_byte  (data_q),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .master   (eng_master),
        .evt      (evt),
        .sto_clr  (sto_clr),
        .evt_code (evt_code),
        .evt_byte (evt_byte)
    );
endmodule

// File: rtl/i2c_seq_master_chk.sv
// Module: assertion checker for the two-wire master, bound to the top.
// Assumes it sees the top's internal register and engine handshake signals.
module i2c_seq_master_chk (
    input logic clk,
    input logic rst_n,
    input logic done_q,
    input logic en_q,
    input logic sto_q,
    input logic wcol_q,
    input logic evt,
    input logic sto_clr,
    input logic ctrl_wr,
    input logic data_wr,
    input logic scl_oe,
    input logic sda_oe,
    input logic master,
    input logic busy
);
    // R2: no line movement while the completion flag holds
    assert_hold_while_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && $past(done_q) && en_q && $past(en_q)) |-> ($stable(scl_oe) && $stable(sda_oe)));

    // R2: completions are only reported while the flag is clear
    assert_evt_flag_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> !done_q);

    // R4: an idle engine only makes a START on a bus it sees as free
    assert_start_on_free_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && !scl_oe && !master) |-> !busy);

    // R6: the STOP request bit drops after the engine finishes a STOP
    assert_stop_self_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sto_clr && !ctrl_wr) |=> !sto_q);

    // R8: a data write with the flag clear raises the collision flag
    assert_wcol_on_busy_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !done_q) |=> wcol_q);

    // R9: a disabled block drives neither line
    assert_release_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && $past(!en_q)) |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_seq_master i2c_seq_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .done_q  (done_q),
    .en_q    (en_q),
    .sto_q   (sto_q),
    .wcol_q  (wcol_q),
    .evt     (evt),
    .sto_clr (sto_clr),
    .ctrl_wr (ctrl_wr),
    .data_wr (data_wr),
    .scl_oe  (scl_oe),
    .sda_oe  (sda_oe),
    .master  (eng_master),
    .busy    (busy)
);

// File: tb/i2c_seq_master_test.sv
// Bench: sweeps every prescaler select through START, address, data,
// repeated START and STOP, with a slave model alternating ACK and NACK,
// then covers deferred START, STOP when not master, abort and reset values.
module i2c_seq_master_test;
    localparam int BD = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       scl_oe, sda_oe, irq;
    logic       ext_sda = 1'b0;
    logic       ext_scl = 1'b0;
    logic       slv_sda = 1'b0;
    logic       ack_mode = 1'b1;
    wire        scl_line = !(scl_oe || ext_scl);
    wire        sda_line = !(sda_oe || ext_sda || slv_sda);

    int checks = 0;
    int fails = 0;
    bit reported = 0;
    int cyc = 0;
    int start_cnt = 0;
    int stop_cnt = 0;
    int scl_rises = 0;
    int seen_start = 0;
    int scnt = 0;
    int rise_prev = 0;
    int rise_last = 0;
    logic [7:0] rxcap = 8'h00;

    i2c_seq_master #(.BASE_DIV(BD), .ADDR_W(2)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .scl_i     (scl_line),
        .sda_i     (sda_line),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .irq       (irq)
    );

    always #10 clk = !clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Bus observers: START/STOP counts, SCL rise timing, captured bits
    always @(negedge sda_line) if (scl_line === 1'b1) start_cnt++;
    always @(posedge sda_line) if (scl_line === 1'b1) stop_cnt++;
    always @(posedge scl_line) begin
        scl_rises++;
        rise_prev = rise_last;
        rise_last = cyc;
        if (scnt < 8) rxcap = {rxcap[6:0], sda_line};
    end

    // Slave model: counts SCL falls since START, answers on the ninth clock
    always @(negedge scl_line) begin
        if (start_cnt != seen_start) begin
            seen_start = start_cnt;
            scnt = 0;
        end else begin
            scnt++;
            if (scnt == 8) slv_sda = ack_mode;
            else if (scnt == 9) begin
                slv_sda = 1'b0;
                scnt = 0;
            end
        end
    end

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
        $finish;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done(input string tag);
        logic [7:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(2'd0, v);
            if (v[7]) return;
        end
        chk({tag, " completion timeout"}, 0, 1);
    endtask

    task automatic wait_sto_clear(input string tag);
        logic [7:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(2'd0, v);
            if (!v[4]) return;
        end
        chk({tag, " stop bit stuck"}, 1, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] addr_b, data_b;
        int s0, p0, r0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(2'd0, v); chk("R1 control reset", v, 8'h00);
        rd(2'd1, v); chk("R1 status reset", v, 8'hF8);
        rd(2'd2, v); chk("R1 data reset", v, 8'hFF);
        chk("R1 irq and drivers", {irq, scl_oe, sda_oe}, 0);

        // R8 collision before any transfer
        wr(2'd0, 8'h05);
        wr(2'd2, 8'h11);
        rd(2'd0, v); chk("R8 collision flag set", v[3], 1);
        rd(2'd2, v); chk("R8 data kept on collision", v, 8'hFF);

        for (int p = 0; p < 4; p++) begin
            ack_mode = (p % 2 == 0);
            addr_b = 8'hA4 ^ 8'(p << 4);
            data_b = 8'h5A + 8'(p * 37);
            wr(2'd1, 8'(p));
            wr(2'd0, 8'h05);

            // R3 START on a free bus
            s0 = start_cnt;
            wr(2'd0, 8'hA5);
            wait_done("R3");
            rd(2'd1, v); chk("R3 start status", v, 8'h08 | p);
            chk("R3 START on bus", start_cnt - s0, 1);
            rd(2'd0, v); chk("R3 start bit kept", v[5], 1);
            chk("R10 irq with flag and enable", irq, 1);

            if (p == 0) begin
                // R2 stall while flag set; R10 interrupt gating
                r0 = scl_rises;
                repeat (200) @(negedge clk);
                chk("R2 no clocks while flag set", scl_rises - r0, 0);
                chk("R2 clock held low", scl_line, 0);
                wr(2'd0, 8'h24);
                chk("R10 irq off with enable clear", irq, 0);
                rd(2'd0, v); chk("R2 writing 0 keeps flag", v[7], 1);
                wr(2'd0, 8'h25);
                chk("R10 irq back on", irq, 1);
            end

            // R5/R8/R12 address byte with a late data write
            wr(2'd2, addr_b);
            rd(2'd0, v); chk("R8 collision cleared by legal write", v[3], 0);
            wr(2'd0, 8'h85);
            chk("R10 irq drops with flag", irq, 0);
            wr(2'd2, 8'h3C);
            rd(2'd0, v); chk("R8 collision during transfer", v[3], 1);
            wait_done("R5 address");
            rd(2'd1, v); chk("R5 address status", v, (ack_mode ? 8'h18 : 8'h20) | p);
            chk("R5 address bits MSB first", rxcap, addr_b);
            rd(2'd2, v); chk("R12 data register holds bus byte", v, addr_b);
            chk("R11 SCL period", rise_last - rise_prev, 4 * BD * (1 << (2 * p)));

            // R5 data byte
            wr(2'd2, data_b);
            wr(2'd0, 8'h85);
            wait_done("R5 data");
            rd(2'd1, v); chk("R5 data status", v, (ack_mode ? 8'h28 : 8'h30) | p);
            chk("R5 data bits MSB first", rxcap, data_b);

            // R13 repeated START
            s0 = start_cnt;
            wr(2'd0, 8'hA5);
            wait_done("R13");
            rd(2'd1, v); chk("R13 repeated start status", v, 8'h10 | p);
            chk("R13 START on bus", start_cnt - s0, 1);

            // R6 STOP as master
            p0 = stop_cnt;
            wr(2'd0, 8'h95);
            wait_sto_clear("R6");
            chk("R6 STOP on bus", stop_cnt - p0, 1);
            rd(2'd1, v); chk("R6 status after stop", v, 8'hF8 | p);
            rd(2'd0, v); chk("R6 flag stays clear", v[7], 0);
        end
        wr(2'd1, 8'h00);
        ack_mode = 1'b1;

        // R4 deferred START behind another master
        ext_sda = 1'b1;
        repeat (10) @(negedge clk);
        wr(2'd0, 8'hA5);
        repeat (300) @(negedge clk);
        rd(2'd0, v); chk("R4 flag clear while bus busy", v[7], 0);
        chk("R4 drivers off while waiting", {scl_oe, sda_oe}, 0);
        s0 = start_cnt;
        ext_sda = 1'b0;
        wait_done("R4");
        rd(2'd1, v); chk("R4 deferred start status", v, 8'h08);
        chk("R4 START after STOP", start_cnt - s0, 1);
        wr(2'd0, 8'h95);
        wait_sto_clear("R4 release");

        // R7 STOP request when not master
        s0 = start_cnt; p0 = stop_cnt;
        wr(2'd0, 8'h15);
        repeat (20) @(negedge clk);
        rd(2'd0, v); chk("R7 stop bit self-clears", v[4], 0);
        chk("R7 no bus conditions", (start_cnt - s0) + (stop_cnt - p0), 0);
        chk("R7 lines released", {scl_oe, sda_oe}, 0);
        rd(2'd1, v); chk("R7 status idle", v, 8'hF8);

        // R9 abort mid-byte
        wr(2'd0, 8'hA5);
        wait_done("R9 start");
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h85);
        repeat (20) @(negedge clk);
        chk("R9 driving before abort", scl_oe || sda_oe, 1);
        wr(2'd0, 8'h00);
        @(negedge clk);
        chk("R9 drivers off after abort", {scl_oe, sda_oe}, 0);
        repeat (500) @(negedge clk);
        rd(2'd0, v); chk("R9 no completion after abort", v, 8'h00);

        // R11 status layout
        wr(2'd1, 8'hFF);
        rd(2'd1, v); chk("R11 reserved bit and prescaler", v[2:0], 3'b011);

        summary();
    end
endmodule